// File: doc/BRIEF.md
# Dithered Two-Phase Delay-Line Clock Generator

This block produces a pair of non-overlapping clock phases for an analog charge-transfer delay line. A 24-bit phase accumulator runs on every system clock and generates a carry once per cycle of its own frequency. That carry passes through a chain of two toggle stages, which gives a reference square wave at one quarter of the accumulator's wrap rate. A complementary output stage then drives `phaseA` while the reference is high and `phaseB` while it is low. Between the fall of one phase and the rise of the other it holds both phases low for a programmable number of clocks.

Running the accumulator four times faster than the wanted output has two effects. The tuning word uses more of its significant bits, so frequency steps are finer. The modulating input is also sampled four times per output period. The increment is not applied continuously. It is captured only when the accumulator wraps, so a modulation source such as a slowly varying control value is resampled once per accumulator cycle. At each capture a two-bit pseudo-random value is added to a nonzero increment, which breaks up the periodic truncation patterns that would otherwise be heard.

Each output edge can land up to one system clock late, because edges happen only on system clock edges. The block therefore runs at the full system clock rate.

Top module: `biphase_nco_clk`

## Requirements
- R1: While `rst` is high, `phaseA` and `phaseB` are both low. Reset clears the accumulator, the active increment and both toggle stages, and it loads the LFSR with 16'hACE1. On the first clock edge after `rst` falls, `phaseB` goes high, because the reference starts low.
- R2: On every clock the 24-bit accumulator adds the active increment, modulo 2^24. The wrap pulse is high in exactly the cycle whose sum carries out of bit 23.
- R3: The first toggle stage flips on every wrap. The second flips on a wrap while the first stage is 1. With an increment of 24'h400000 the reference, and so `phaseA`, has a period of 16 clocks. With 24'h200000 the period is 32 clocks.
- R4: `incIn` is copied into the active increment only on a wrap cycle, or on any cycle in which the active increment is zero. A value held on `incIn` between wraps has no effect.
- R5: The captured value is `incIn` plus LFSR bits [1:0]. The LFSR is 16 bits wide, shifts left, and takes as its new bit 0 the XOR of bits 15, 13, 12 and 10. It advances once per wrap, after its current low bits are used.
- R6: If the dithered sum exceeds 24'hFFFFFF, the captured value saturates at 24'hFFFFFF. With `incIn` = 24'hFFFFFF the accumulator wraps on every clock once running, so `phaseA` rises once every 4 clocks.
- R7: `phaseA` and `phaseB` are never high in the same cycle.
- R8: When either phase falls and `deadCnt` = N > 0, both phases stay low for exactly N clocks, then the phase chosen by the reference rises. When N = 0 the other phase rises on the same edge on which the first one falls.
- R9: An `incIn` of zero is captured as zero, with no dither. The accumulator then stops and both phases hold their levels without any edge. A later nonzero `incIn` is captured on the next clock, and the outputs resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the accumulator and every register run on it |
| rst | input | 1 | Synchronous active-high reset |
| incIn | input | 24 | Frequency increment, captured on wrap |
| deadCnt | input | 4 | Number of clocks with both phases low between phase changes |
| phaseA | output | 1 | Phase driven while the reference is high |
| phaseB | output | 1 | Phase driven while the reference is low |

## Verification
A wrap is visible in the same cycle as the carry. The toggle stages register it one edge later, and the output stage adds one more edge, so a phase change lands two clocks after the wrap cycle that causes it. A dead band then adds exactly `deadCnt` clocks before the opposite phase rises. The bench keeps a cycle-accurate reference of the accumulator, dither and output stage, built from the requirements and updated on the same rising edge as the design. It compares that reference with both phases at every falling edge, so each latency above is checked in the exact cycle it is due. Rates, dead-band widths and frozen outputs are measured from the phase waveforms over windows long enough that a one-cycle offset cannot change the result.

// File: rtl/nco_clk_pkg.sv
package nco_clk_pkg;

  // Strobes the control issues to the datapath each cycle.
  typedef struct packed {
    logic loadInc;   // capture the dithered increment
    logic stepLfsr;  // advance the dither generator
  } dpStrobe_t;

endpackage

// File: rtl/nco_clk_datapath.sv
module nco_clk_datapath
  import nco_clk_pkg::*;
#(
  parameter int ACC_W    = 24,
  parameter int LFSR_W   = 16,
  parameter int DITHER_W = 2,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] incIn,
  input  dpStrobe_t        strb,
  output logic             carryOut,
  output logic             incZero
);

  localparam logic [ACC_W-1:0] INC_MAX = {ACC_W{1'b1}};
  localparam int PAD_W = ACC_W + 1 - DITHER_W;

  logic [ACC_W-1:0]  accQ;
  logic [ACC_W-1:0]  incQ;
  logic [LFSR_W-1:0] lfsrQ;
  logic [ACC_W:0]    accSum;
  logic [ACC_W:0]    dithSum;
  logic [ACC_W-1:0]  incNext;
  logic              lfsrFb;

  always_comb begin
    accSum  = {1'b0, accQ} + {1'b0, incQ};
    dithSum = {1'b0, incIn} + {{PAD_W{1'b0}}, lfsrQ[DITHER_W-1:0]};
    if (incIn == '0)
      incNext = '0;
    else if (dithSum[ACC_W])
      incNext = INC_MAX;
    else
      incNext = dithSum[ACC_W-1:0];
    lfsrFb = ^(lfsrQ & LFSR_TAPS);
  end

  assign carryOut = accSum[ACC_W];
  assign incZero  = (incQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ  <= '0;
      incQ  <= '0;
      lfsrQ <= LFSR_SEED;
    end else begin
      accQ <= accSum[ACC_W-1:0];
      if (strb.loadInc)
        incQ <= incNext;
      if (strb.stepLfsr)
        lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrFb};
    end
  end

endmodule

// File: rtl/nco_clk_ctrl.sv
module nco_clk_ctrl
  import nco_clk_pkg::*;
#(
  parameter int DIV_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      carry,
  input  logic      incZero,
  output dpStrobe_t strb,
  output logic      refLevel
);

  logic [DIV_STAGES-1:0] stageQ;
  logic [DIV_STAGES-1:0] stageTgl;

  always_comb begin
    strb.loadInc  = carry | incZero;
    strb.stepLfsr = carry;
  end

  for (genvar g = 0; g < DIV_STAGES; g++) begin : gDiv
    if (g == 0) begin : gFirst
      assign stageTgl[g] = carry;
    end else begin : gNext
      assign stageTgl[g] = stageTgl[g-1] & stageQ[g-1];
    end

    always_ff @(posedge clk) begin
      if (rst)
        stageQ[g] <= 1'b0;
      else if (stageTgl[g])
        stageQ[g] <= ~stageQ[g];
    end
  end

  assign refLevel = stageQ[DIV_STAGES-1];

endmodule

// File: rtl/nco_clk_phase_out.sv
module nco_clk_phase_out #(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refLevel,
  input  logic [DEAD_W-1:0] deadCnt,
  output logic              phaseA,
  output logic              phaseB
);

  logic [DEAD_W-1:0] gapQ;
  logic              aQ;
  logic              bQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      aQ   <= 1'b0;
      bQ   <= 1'b0;
      gapQ <= '0;
    end else if (aQ && !refLevel) begin
      aQ <= 1'b0;
      if (deadCnt == '0) bQ <= 1'b1;
      else               gapQ <= deadCnt - 1'b1;
    end else if (bQ && refLevel) begin
      bQ <= 1'b0;
      if (deadCnt == '0) aQ <= 1'b1;
      else               gapQ <= deadCnt - 1'b1;
    end else if (!aQ && !bQ) begin
      if (gapQ != '0) begin
        gapQ <= gapQ - 1'b1;
      end else begin
        aQ <= refLevel;
        bQ <= ~refLevel;
      end
    end
  end

  assign phaseA = aQ;
  assign phaseB = bQ;

endmodule

// File: rtl/biphase_nco_clk.sv
module biphase_nco_clk
  import nco_clk_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int DEAD_W     = 4,
  parameter int DIV_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  incIn,
  input  logic [DEAD_W-1:0] deadCnt,
  output logic              phaseA,
  output logic              phaseB
);

  dpStrobe_t strb;
  logic      wrapPulse;
  logic      incZero;
  logic      refLevel;

  nco_clk_datapath #(.ACC_W(ACC_W)) dpInst (
    .clk(clk), .rst(rst), .incIn(incIn), .strb(strb),
    .carryOut(wrapPulse), .incZero(incZero)
  );

  nco_clk_ctrl #(.DIV_STAGES(DIV_STAGES)) ctrlInst (
    .clk(clk), .rst(rst), .carry(wrapPulse), .incZero(incZero),
    .strb(strb), .refLevel(refLevel)
  );

  nco_clk_phase_out #(.DEAD_W(DEAD_W)) outInst (
    .clk(clk), .rst(rst), .refLevel(refLevel), .deadCnt(deadCnt),
    .phaseA(phaseA), .phaseB(phaseB)
  );

endmodule

// File: rtl/biphase_nco_clk_chk.sv
module biphase_nco_clk_chk #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          phaseA,
  input logic          phaseB,
  input logic          wrapPulse,
  input logic          refLevel,
  input logic [DW-1:0] deadCnt
);

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(phaseA && phaseB));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (!phaseA && !phaseB));

  // R3
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrapPulse |=> $stable(refLevel));

  // R8
  dead_a_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(phaseA) && deadCnt != '0) |-> !phaseB);

  // R8
  dead_b_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(phaseB) && deadCnt != '0) |-> !phaseA);

endmodule

bind biphase_nco_clk biphase_nco_clk_chk #(.DW(DEAD_W)) chkInst (
  .clk(clk), .rst(rst), .phaseA(phaseA), .phaseB(phaseB),
  .wrapPulse(wrapPulse), .refLevel(refLevel), .deadCnt(deadCnt)
);

// File: tb/biphase_nco_clk_test.sv
`timescale 1ns/1ps
module biphase_nco_clk_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] incIn = '0;
  logic [3:0]  deadCnt = '0;
  logic        phaseA, phaseB;

  always #2 clk = ~clk;

  biphase_nco_clk uut (
    .clk(clk), .rst(rst), .incIn(incIn), .deadCnt(deadCnt),
    .phaseA(phaseA), .phaseB(phaseB)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model built from R1..R9
  logic [23:0] mAcc, mInc;
  logic [15:0] mL;
  logic        mD0, mD1, mA, mB;
  logic [3:0]  mGap;

  always @(posedge clk) begin : refModel
    logic [24:0] s, t;
    logic [23:0] d;
    logic        c;
    if (rst) begin
      mAcc <= '0; mInc <= '0; mL <= 16'hACE1;
      mD0 <= 1'b0; mD1 <= 1'b0; mA <= 1'b0; mB <= 1'b0; mGap <= '0;
    end else begin
      s = {1'b0, mAcc} + {1'b0, mInc};
      c = s[24];
      mAcc <= s[23:0];
      t = {1'b0, incIn} + {23'b0, mL[1:0]};
      d = (incIn == 0) ? 24'h0 : (t[24] ? 24'hFFFFFF : t[23:0]);
      if (c || mInc == 0) mInc <= d;
      if (c) mL <= {mL[14:0], mL[15] ^ mL[13] ^ mL[12] ^ mL[10]};
      if (c) mD0 <= ~mD0;
      if (c && mD0) mD1 <= ~mD1;
      if (mA && !mD1) begin
        mA <= 1'b0;
        if (deadCnt == 0) mB <= 1'b1; else mGap <= deadCnt - 1'b1;
      end else if (mB && mD1) begin
        mB <= 1'b0;
        if (deadCnt == 0) mA <= 1'b1; else mGap <= deadCnt - 1'b1;
      end else if (!mA && !mB) begin
        if (mGap != 0) mGap <= mGap - 1'b1;
        else begin mA <= mD1; mB <= ~mD1; end
      end
    end
  end

  // Per-segment observations
  int segMis, overlapCnt, lowRun, gapMin, gapMax, gapSeen, riseA, edgeCnt;
  int misAct, misExp;
  logic prevA, prevB, seenFall;

  task automatic clearSeg();
    segMis = 0; overlapCnt = 0; lowRun = 0; gapMin = 99; gapMax = -1;
    gapSeen = 0; riseA = 0; edgeCnt = 0; seenFall = 1'b0;
    prevA = 1'b0; prevB = 1'b0; misAct = 0; misExp = 0;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (!rst) begin
      if (phaseA !== mA || phaseB !== mB) begin
        if (segMis == 0) begin misAct = {phaseA, phaseB}; misExp = {mA, mB}; end
        segMis++;
      end
      if (phaseA && phaseB) overlapCnt++;
      if (phaseA != prevA || phaseB != prevB) edgeCnt++;
      if (!phaseA && !phaseB) lowRun++;
      else begin
        if (((phaseA && !prevA) || (phaseB && !prevB)) && seenFall) begin
          gapSeen++;
          if (lowRun < gapMin) gapMin = lowRun;
          if (lowRun > gapMax) gapMax = lowRun;
        end
        lowRun = 0;
      end
      if ((prevA && !phaseA) || (prevB && !phaseB)) seenFall = 1'b1;
      if (phaseA && !prevA) riseA++;
      prevA = phaseA; prevB = phaseB;
    end
  endtask

  task automatic doReset(input logic [23:0] inc, input logic [3:0] dead);
    rst = 1'b1;
    incIn = inc; deadCnt = dead;
    repeat (3) tick();
    check(phaseA === 1'b0 && phaseB === 1'b0, "R1", "outputs low in reset",
          {phaseA, phaseB}, 0);
    rst = 1'b0;
    clearSeg();
    tick();
    check(phaseA === 1'b0 && phaseB === 1'b1, "R1", "phaseB first after reset",
          {phaseA, phaseB}, 1);
  endtask

  typedef struct packed {
    logic [23:0] inc;
    logic [3:0]  dead;
    logic [15:0] cycles;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{24'h400000, 4'd2,  16'd800},
    '{24'h123457, 4'd0,  16'd800},
    '{24'h0A0000, 4'd5,  16'd2000},
    '{24'hFFFFFF, 4'd3,  16'd400},
    '{24'h7FFFFF, 4'd1,  16'd600},
    '{24'h200001, 4'd15, 16'd1500},
    '{24'hF00000, 4'd7,  16'd600}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    // Vector table: waveform vs reference, overlap, dead band
    for (int i = 0; i < 7; i++) begin
      doReset(VECS[i].inc, VECS[i].dead);
      repeat (int'(VECS[i].cycles)) tick();
      check(segMis == 0, "R2 R5 R6", "phases match reference", misAct, misExp);
      check(overlapCnt == 0, "R7", "cycles with both phases high", overlapCnt, 0);
      check(gapSeen > 0 && gapMin == int'(VECS[i].dead) && gapMax == int'(VECS[i].dead),
            "R8", "dead-band width", (gapMin == int'(VECS[i].dead)) ? gapMax : gapMin,
            int'(VECS[i].dead));
    end

    // R3: divide by four, period 16 clocks
    doReset(24'h400000, 4'd0);
    repeat (64) tick();
    riseA = 0;
    repeat (1600) tick();
    check(riseA >= 99 && riseA <= 101, "R3", "phaseA rises, inc 0x400000", riseA, 100);

    // R3: period 32 clocks
    doReset(24'h200000, 4'd1);
    repeat (64) tick();
    riseA = 0;
    repeat (1600) tick();
    check(riseA >= 49 && riseA <= 51, "R3", "phaseA rises, inc 0x200000", riseA, 50);

    // R6: saturation gives a wrap on every clock
    doReset(24'hFFFFFF, 4'd0);
    repeat (20) tick();
    riseA = 0;
    repeat (400) tick();
    check(riseA >= 99 && riseA <= 101, "R6", "phaseA rises at saturated inc", riseA, 100);

    // R4: a value held between wraps is ignored
    doReset(24'h010000, 4'd1);
    repeat (100) tick();
    incIn = 24'hF00000;
    repeat (30) tick();
    incIn = 24'h010000;
    check(riseA == 0, "R4", "phaseA rises after mid-cycle change", riseA, 0);
    repeat (2000) tick();
    check(segMis == 0, "R4", "phases match reference", misAct, misExp);

    // R9: zero increment freezes outputs; restart afterwards
    doReset(24'h100000, 4'd2);
    repeat (300) tick();
    incIn = 24'h0;
    repeat (100) tick();
    edgeCnt = 0;
    repeat (400) tick();
    check(edgeCnt == 0, "R9", "edges while stopped", edgeCnt, 0);
    incIn = 24'h100000;
    riseA = 0;
    repeat (200) tick();
    check(riseA > 0, "R9", "phaseA rises after restart", riseA, 1);
    check(segMis == 0, "R9", "phases match reference", misAct, misExp);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule